// File: doc/BRIEF.md
# Byte-Lane Memory Access Unit

This unit connects a 16-bit processor datapath to a memory made of two 8-bit banks placed side by side. The low bank holds the bytes at even addresses and the high bank holds the bytes at odd addresses. One row of the two banks together forms a 16-bit word. The datapath presents one request per cycle. Each request carries:

- a byte address,
- a size (byte or word),
- a direction (read or write),
- a sign-extension flag for byte loads,
- 16 bits of write data.

The unit drives a row address, an enable and a write strobe for each bank. It also moves bytes between the banks and the datapath.

Inside the unit, the size and the low address bit are turned into an active-low upper-lane enable. The lane choice is decoded from that enable together with address bit 0. An aligned word moves both bytes in one cycle. A byte access touches only its own bank. On a read, the byte is returned in the low eight bits of the result and is extended with zeros or with its sign bit.

An odd-address word is handled separately. The low bank is given the next row and the high bank the current row, and the two byte lanes are swapped. The banks are synchronous, so read data and a done pulse appear in the cycle after the request.

Top module: `lane_access_unit`

## Requirements
- R1: For byte accesses and even-address word accesses, both bank row addresses equal the byte address shifted right by one.
- R2: A byte request at an even address enables only the low bank. A byte request at an odd address enables only the high bank. Internally the active-low upper enable is 0 exactly for words and odd bytes, and the pairing (enable high, bit 0 high) selects no bank.
- R3: While `reqValid` is 0, neither bank is enabled and neither write strobe is asserted.
- R4: An even-address word request enables both banks in the request cycle. Bits 7:0 of the word are held in the low bank and bits 15:8 in the high bank, for both reads and writes.
- R5: A byte read returns the addressed byte in `rdData[7:0]`, whichever bank holds it.
- R6: For a byte read, `rdData[15:8]` is zero when `reqSigned` is 0, and is eight copies of bit 7 of the byte when `reqSigned` is 1.
- R7: A byte write places `reqWdata[7:0]` on both bank write-data buses but asserts only the addressed bank's strobe. The other byte of that word is left unchanged.
- R8: An odd-address word request drives the high bank with row r = address>>1 and the low bank with row r+1. Row r+1 wraps to 0 at the top row. A read returns the byte at the request address in bits 7:0 and the byte at the next address in bits 15:8.
- R9: An odd-address word write asserts both strobes. It sends `reqWdata[7:0]` to the high bank (row r) and `reqWdata[15:8]` to the low bank (row r+1).
- R10: `done` is 0 in reset and is 1 exactly in the cycle after each accepted request. `rdData` is valid in that cycle.
- R11: On word reads `reqSigned` has no effect. The full 16-bit word is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit word, 0 = byte |
| reqSigned | input | 1 | Sign-extend byte reads |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 16 | Write data |
| loRowAddr | output | ADDR_W-1 | Low bank row address |
| loEn | output | 1 | Low bank enable |
| loWe | output | 1 | Low bank write strobe |
| loWdata | output | 8 | Low bank write data |
| loRdata | input | 8 | Low bank read data (one cycle after enable) |
| hiRowAddr | output | ADDR_W-1 | High bank row address |
| hiEn | output | 1 | High bank enable |
| hiWe | output | 1 | High bank write strobe |
| hiWdata | output | 8 | High bank write data |
| hiRdata | input | 8 | High bank read data (one cycle after enable) |
| rdData | output | 16 | Steered and extended read result |
| done | output | 1 | Access complete, read data valid |

## Verification
The properties assume that the request fields are known whenever `reqValid` is high. They also assume that the banks return the addressed row on the edge that follows an enabled read. There is no stall, so every request is taken in its own cycle. The bench drives all request inputs half a cycle away from the active edge and holds them at zero during reset. Its bank model is a plain single-cycle synchronous array. Stimulus is weighted toward odd addresses near the top row, so that the wrap of row r+1 is reached often.

// File: rtl/lane_access_pkg.sv
package lane_access_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int LANES  = WORD_W / BYTE_W;

  // How the write data is placed onto the two bank buses
  typedef enum logic [1:0] {
    WD_STRAIGHT  = 2'd0,
    WD_REPLICATE = 2'd1,
    WD_SWAP      = 2'd2
  } wrSteer_e;

  // How the returned bank bytes are assembled into the result
  typedef enum logic [1:0] {
    RD_WORD      = 2'd0,
    RD_WORD_SWAP = 2'd1,
    RD_BYTE_LO   = 2'd2,
    RD_BYTE_HI   = 2'd3
  } rdSteer_e;

  // Strobes from control to datapath in the request cycle
  typedef struct packed {
    logic     loEn;
    logic     hiEn;
    logic     loWe;
    logic     hiWe;
    logic     bumpLo;
    wrSteer_e wrSteer;
  } laneCmd_t;

  // Context kept for the return cycle
  typedef struct packed {
    rdSteer_e steer;
    logic     sext;
  } rdCtx_t;

endpackage

// File: rtl/lane_access_ctrl.sv
module lane_access_ctrl
  import lane_access_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     reqWord,
  input  logic     reqSigned,
  input  logic     addrLsb,
  output laneCmd_t cmd,
  output rdCtx_t   rdCtx,
  output logic     done
);

  logic     hiLaneN;
  logic     unaligned;
  logic     laneLo;
  logic     laneHi;
  rdSteer_e nextSteer;
  wrSteer_e nextWr;

  // Active-low upper-lane enable, as the datapath would present it
  assign hiLaneN   = ~(reqWord | addrLsb);
  assign unaligned = reqWord & addrLsb;

  always_comb begin
    laneLo    = 1'b0;
    laneHi    = 1'b0;
    nextSteer = RD_WORD;
    nextWr    = WD_STRAIGHT;
    if (unaligned) begin
      laneLo    = 1'b1;
      laneHi    = 1'b1;
      nextSteer = RD_WORD_SWAP;
      nextWr    = WD_SWAP;
    end else begin
      unique case ({hiLaneN, addrLsb})
        2'b00: begin
          laneLo    = 1'b1;
          laneHi    = 1'b1;
          nextSteer = RD_WORD;
          nextWr    = WD_STRAIGHT;
        end
        2'b01: begin
          laneHi    = 1'b1;
          nextSteer = RD_BYTE_HI;
          nextWr    = WD_REPLICATE;
        end
        2'b10: begin
          laneLo    = 1'b1;
          nextSteer = RD_BYTE_LO;
          nextWr    = WD_REPLICATE;
        end
        default: begin
          // no lane selected: nothing enabled
          laneLo = 1'b0;
          laneHi = 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    cmd.loEn    = reqValid & laneLo;
    cmd.hiEn    = reqValid & laneHi;
    cmd.loWe    = reqValid & laneLo & reqWrite;
    cmd.hiWe    = reqValid & laneHi & reqWrite;
    cmd.bumpLo  = unaligned;
    cmd.wrSteer = nextWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done        <= 1'b0;
      rdCtx.steer <= RD_WORD;
      rdCtx.sext  <= 1'b0;
    end else begin
      done <= reqValid;
      if (reqValid) begin
        rdCtx.steer <= nextSteer;
        rdCtx.sext  <= reqSigned & ~reqWord;
      end
    end
  end

endmodule

// File: rtl/lane_access_dp.sv
module lane_access_dp
  import lane_access_pkg::*;
#(
  parameter int ROW_W = 9
) (
  input  logic [ROW_W-1:0]  reqRow,
  input  laneCmd_t          cmd,
  input  logic [WORD_W-1:0] reqWdata,
  input  rdCtx_t            rdCtx,
  input  logic [BYTE_W-1:0] loRdata,
  input  logic [BYTE_W-1:0] hiRdata,
  output logic [ROW_W-1:0]  loRowAddr,
  output logic [ROW_W-1:0]  hiRowAddr,
  output logic [BYTE_W-1:0] loWdata,
  output logic [BYTE_W-1:0] hiWdata,
  output logic [WORD_W-1:0] rdData
);

  logic [BYTE_W-1:0] laneWr [LANES];

  // Row addresses: low bank moves to the next row for odd-address words
  assign hiRowAddr = reqRow;
  assign loRowAddr = reqRow + {{(ROW_W-1){1'b0}}, cmd.bumpLo};

  // Per-lane write-data selection
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_comb begin
      unique case (cmd.wrSteer)
        WD_REPLICATE: laneWr[g] = reqWdata[BYTE_W-1:0];
        WD_SWAP:      laneWr[g] = reqWdata[(LANES-1-g)*BYTE_W +: BYTE_W];
        default:      laneWr[g] = reqWdata[g*BYTE_W +: BYTE_W];
      endcase
    end
  end

  assign loWdata = laneWr[0];
  assign hiWdata = laneWr[1];

  function automatic logic [WORD_W-1:0] extendByte(input logic [BYTE_W-1:0] b,
                                                   input logic sx);
    return {{(WORD_W-BYTE_W){sx & b[BYTE_W-1]}}, b};
  endfunction

  // Return-cycle read steering
  always_comb begin
    unique case (rdCtx.steer)
      RD_WORD_SWAP: rdData = {loRdata, hiRdata};
      RD_BYTE_LO:   rdData = extendByte(loRdata, rdCtx.sext);
      RD_BYTE_HI:   rdData = extendByte(hiRdata, rdCtx.sext);
      default:      rdData = {hiRdata, loRdata};
    endcase
  end

endmodule

// File: rtl/lane_access_unit.sv
module lane_access_unit
  import lane_access_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int ROW_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic              reqSigned,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  output logic [ROW_W-1:0]  loRowAddr,
  output logic              loEn,
  output logic              loWe,
  output logic [7:0]        loWdata,
  input  logic [7:0]        loRdata,
  output logic [ROW_W-1:0]  hiRowAddr,
  output logic              hiEn,
  output logic              hiWe,
  output logic [7:0]        hiWdata,
  input  logic [7:0]        hiRdata,
  output logic [15:0]       rdData,
  output logic              done
);

  laneCmd_t cmd;
  rdCtx_t   rdCtx;

  lane_access_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqWord   (reqWord),
    .reqSigned (reqSigned),
    .addrLsb   (reqAddr[0]),
    .cmd       (cmd),
    .rdCtx     (rdCtx),
    .done      (done)
  );

  lane_access_dp #(.ROW_W(ROW_W)) u_dp (
    .reqRow    (reqAddr[ADDR_W-1:1]),
    .cmd       (cmd),
    .reqWdata  (reqWdata),
    .rdCtx     (rdCtx),
    .loRdata   (loRdata),
    .hiRdata   (hiRdata),
    .loRowAddr (loRowAddr),
    .hiRowAddr (hiRowAddr),
    .loWdata   (loWdata),
    .hiWdata   (hiWdata),
    .rdData    (rdData)
  );

  assign loEn = cmd.loEn;
  assign hiEn = cmd.hiEn;
  assign loWe = cmd.loWe;
  assign hiWe = cmd.hiWe;

endmodule

// File: rtl/lane_access_chk.sv
module lane_access_chk #(
  parameter int ADDR_W = 10,
  localparam int ROW_W = ADDR_W - 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqWord,
  input logic              reqSigned,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [15:0]       reqWdata,
  input logic [ROW_W-1:0]  loRowAddr,
  input logic              loEn,
  input logic              loWe,
  input logic [7:0]        loWdata,
  input logic [ROW_W-1:0]  hiRowAddr,
  input logic              hiEn,
  input logic              hiWe,
  input logic [7:0]        hiWdata,
  input logic [15:0]       rdData,
  input logic              done
);

  // R1
  row_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(reqWord && reqAddr[0])) |->
      (loRowAddr == reqAddr[ADDR_W-1:1] && hiRowAddr == reqAddr[ADDR_W-1:1]));

  // R2
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWord) |-> ($onehot({loEn, hiEn}) && (hiEn == reqAddr[0])));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!loEn && !hiEn && !loWe && !hiWe));

  // R4
  word_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWord && !reqAddr[0]) |-> (loEn && hiEn && (loWe == reqWrite) && (hiWe == reqWrite)));

  // R6
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(reqValid && !reqWrite && !reqWord && !reqSigned)) |-> (rdData[15:8] == 8'h00));

  // R6
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(reqValid && !reqWrite && !reqWord && reqSigned)) |-> (rdData[15:8] == {8{rdData[7]}}));

  // R7
  byte_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqWord) |->
      ($countones({loWe, hiWe}) == 1 && loWdata == reqWdata[7:0] && hiWdata == reqWdata[7:0]));

  // R8
  unaligned_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWord && reqAddr[0]) |->
      (hiRowAddr == reqAddr[ADDR_W-1:1] && loRowAddr == ROW_W'(hiRowAddr + 1'b1)));

  // R9
  unaligned_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqWord && reqAddr[0]) |->
      (loWe && hiWe && hiWdata == reqWdata[7:0] && loWdata == reqWdata[15:8]));

  // R10
  done_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !done);

endmodule

bind lane_access_unit lane_access_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_lane_access_unit.sv
`timescale 1ns/1ps
module sim_lane_access_unit;

  localparam int ADDR_W = 10;
  localparam int ROW_W  = ADDR_W - 1;
  localparam int ROWS   = 1 << ROW_W;
  localparam int NB     = 1 << ADDR_W;
  localparam real HALF  = 10.0;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0, reqSigned = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [15:0]       reqWdata = '0;
  logic [ROW_W-1:0]  loRowAddr, hiRowAddr;
  logic              loEn, loWe, hiEn, hiWe, done;
  logic [7:0]        loWdata, hiWdata, loRdata, hiRdata;
  logic [15:0]       rdData;

  logic [7:0] loMem  [ROWS];
  logic [7:0] hiMem  [ROWS];
  logic [7:0] refMem [NB];

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;
  logic sentValid = 1'b0;

  always #(HALF) clk = ~clk;

  lane_access_unit #(.ADDR_W(ADDR_W)) u0 (.*);

  // Synchronous bank models
  always @(posedge clk) begin
    if (loEn) begin
      if (loWe) loMem[loRowAddr] <= loWdata;
      else      loRdata <= loMem[loRowAddr];
    end
    if (hiEn) begin
      if (hiWe) hiMem[hiRowAddr] <= hiWdata;
      else      hiRdata <= hiMem[hiRowAddr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Per-cycle completion check (R10)
  always @(posedge clk) sentValid <= rstN && reqValid;
  always @(negedge clk) if (rstN && !finished) chk(done === sentValid, "R10", {31'd0, done}, {31'd0, sentValid});

  task automatic access(input bit wr, input bit wd, input bit sg, input int a, input logic [15:0] w);
    int row, loRow, a1;
    bit unal, eLo, eHi;
    logic [15:0] exp;
    string tag;
    a     = a % NB;
    a1    = (a + 1) % NB;
    row   = a >> 1;
    unal  = wd && a[0];
    loRow = unal ? (row + 1) % ROWS : row;
    eLo   = wd || !a[0];
    eHi   = wd || a[0];
    reqValid = 1'b1; reqWrite = wr; reqWord = wd; reqSigned = sg;
    reqAddr = a[ADDR_W-1:0]; reqWdata = w;
    #2;
    tag = wd ? (unal ? "R8" : "R4") : "R2";
    chk(loEn === eLo && hiEn === eHi, tag, {loEn, hiEn}, {eLo, eHi});
    tag = unal ? "R8" : "R1";
    chk(hiRowAddr == row[ROW_W-1:0] && loRowAddr == loRow[ROW_W-1:0], tag,
        {loRowAddr, 7'd0, hiRowAddr}, {loRow[ROW_W-1:0], 7'd0, row[ROW_W-1:0]});
    if (wr) begin
      if (!wd) begin
        chk(loWe === eLo && hiWe === eHi && loWdata == w[7:0] && hiWdata == w[7:0], "R7",
            {loWe, hiWe, loWdata, hiWdata}, {eLo, eHi, w[7:0], w[7:0]});
      end else if (unal) begin
        chk(loWe && hiWe && hiWdata == w[7:0] && loWdata == w[15:8], "R9",
            {loWe, hiWe, loWdata, hiWdata}, {2'b11, w[15:8], w[7:0]});
      end else begin
        chk(loWe && hiWe && loWdata == w[7:0] && hiWdata == w[15:8], "R4",
            {loWe, hiWe, loWdata, hiWdata}, {2'b11, w[7:0], w[15:8]});
      end
    end else begin
      chk(!loWe && !hiWe, "R4", {loWe, hiWe}, 0);
    end
    if (wd) exp = {refMem[a1], refMem[a]};
    else    exp = {(sg && refMem[a][7]) ? 8'hFF : 8'h00, refMem[a]};
    @(posedge clk);
    if (wr) begin
      refMem[a] = w[7:0];
      if (wd) refMem[a1] = w[15:8];
    end
    @(negedge clk);
    chk(done === 1'b1, "R10", {31'd0, done}, 1);
    if (!wr) begin
      if (wd) tag = unal ? "R8" : (sg ? "R11" : "R4");
      else    tag = sg ? "R6" : "R5";
      chk(rdData === exp, tag, rdData, exp);
    end
  endtask

  task automatic idle();
    reqValid = 1'b0; reqWrite = 1'b0; reqWord = 1'b0; reqSigned = 1'b0;
    #2;
    chk(!loEn && !hiEn && !loWe && !hiWe, "R3", {loEn, hiEn, loWe, hiWe}, 0);
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired: actual hung expected finished");
    finish();
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      refMem[i] = 8'((i * 37 + 5) & 255);
      if (i[0]) hiMem[i >> 1] = refMem[i];
      else      loMem[i >> 1] = refMem[i];
    end
    loRdata = '0;
    hiRdata = '0;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && !loEn && !hiEn, "R10", {done, loEn, hiEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    idle();

    // R5 / R6: byte reads, both banks, both extensions
    access(0, 0, 0, 6, 16'h0);
    access(0, 0, 0, 7, 16'h0);
    access(0, 0, 1, 3, 16'h0);
    access(0, 0, 1, 4, 16'h0);
    // R4 / R11: aligned word reads
    access(0, 1, 0, 20, 16'h0);
    access(0, 1, 1, 22, 16'h0);
    // R8: unaligned read, also at the top row
    access(0, 1, 0, 21, 16'h0);
    access(0, 1, 0, NB - 1, 16'h0);
    // R7: byte writes, then confirm neighbour untouched
    access(1, 0, 0, 40, 16'hAB91);
    access(1, 0, 0, 43, 16'h5CE7);
    access(0, 1, 0, 40, 16'h0);
    access(0, 1, 0, 42, 16'h0);
    access(0, 0, 1, 43, 16'h0);
    idle();
    // R4 / R9: word writes, aligned, unaligned, at top
    access(1, 1, 0, 60, 16'h1234);
    access(1, 1, 0, 63, 16'hBEEF);
    access(1, 1, 0, NB - 1, 16'hC0DE);
    access(0, 1, 0, 62, 16'h0);
    access(0, 1, 0, 64, 16'h0);
    access(0, 1, 0, NB - 2, 16'h0);
    access(0, 1, 0, 0, 16'h0);
    access(0, 1, 0, NB - 1, 16'h0);
    idle();

    for (int i = 0; i < 3000; i++) begin
      int a;
      a = ($urandom % 4 == 0) ? NB - 1 - int'($urandom % 4) : int'($urandom % NB);
      access(1'($urandom), 1'($urandom), 1'($urandom), a, 16'($urandom));
      if ($urandom % 16 == 0) idle();
    end
    idle();
    idle();
    finish();
  end

endmodule